// File: doc/BRIEF.md
# Seven-Level Inverter Gate Pattern Generator

This block drives the ten power switches of a reduced-switch, seven-level inverter. The switch bank has two parts. A level stage puts 0, 1, 2 or 3 units of DC voltage across the load and switches at carrier rate. A polarity stage steers that voltage positive or negative and changes state only at line frequency. The block builds its own digital sine reference from a phase accumulator and a quarter-wave table with linear interpolation. It scales the reference by an amplitude word and compares its magnitude against a triangular carrier stacked at three offsets. The number of thresholds exceeded is the output level.

A fixed table maps each level to the six level-stage switches. The sign of the current half line cycle selects which pair of polarity switches conducts. The user sets the line frequency with a tuning word and the modulation index with an amplitude word. One sample is taken per clock. The registered 10-bit gate vector goes straight to the gate drivers, with dead-time inserted downstream.

Top module: `ml7_gate_gen`

## Requirements
- R1: While rst_n is low, gate_o is all zeros. After release it stays zero through the first rising edge. From the second rising edge onward it carries the pattern for sample 0, and it never returns to zero until the next reset.
- R2: The phase starts at 0 and advances by ftw_i every clock, modulo 2^16. The reference magnitude is amp_i/256 × 4095 × |sin(2π·phase/65536)|, within ±10 LSB.
- R3: The carrier starts at 0, rising. Each sample it steps by 65 toward the peak 1365 (one third of full scale 4095), clamping at the peak and turning down there. It then steps down by 65, clamping at 0 and turning up there.
- R4: The level counts how many k in {1,2,3} satisfy |ref| > (k−1)·1365 + carrier, using the reference and carrier of the same sample.
- R5: Gate bit i−1 drives switch Si. The low six bits are 6'b101010 for level 0, 6'b011010 for level 1, 6'b000110 for level 2 and 6'b000001 for level 3. No other low-six pattern appears once the output is valid.
- R6: Whenever the output is valid, S2 (bit 1) is the inverse of S1 (bit 0).
- R7: When phase bit 15 is 0, S7 and S8 (bits 6,7) are on and S9 and S10 (bits 8,9) are off. When it is 1, the pairs swap. The S1–S6 pattern is unchanged by polarity, including at level 0.
- R8: With amp_i = 0 the level is 0 on every sample.
- R9: The modulation index is amp_i/256. At the nominal value 230 (≈0.9), each half line cycle contains samples at level 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, release synchronous to clk |
| ftw_i | input | 16 | Line-frequency tuning word added to the phase each clock |
| amp_i | input | 8 | Reference amplitude, modulation index = amp_i/256 |
| gate_o | output | 10 | Gate commands, bit i−1 drives switch Si |

## Verification
The hardest conditions to reach from the ports are the negative half-cycle at level 0 and level 3 at the exact crest of the reference. In normal operation, the zero crossing and the crest each occupy only a few samples. A tuning word of 0x8000 flips polarity on every sample while the reference sits at zero, so the negative-polarity level-0 pattern appears on every other sample. A tuning word of 0x4000 at full amplitude visits the positive and negative crests every four samples while the carrier sweeps its whole range, so the level-3 pattern appears in both polarities. A zero amplitude run and a zero tuning word run pin the reference at zero.

// File: rtl/ml7_pkg.sv
package ml7_pkg;

  localparam int MAG_W    = 12;
  localparam int MAG_MAX  = 4095;
  localparam int LUT_AW   = 4;
  localparam int N_CMP    = 3;
  localparam int N_SW     = 10;
  localparam int CAR_PEAK = MAG_MAX / N_CMP;

  typedef logic [1:0] level_t;

  // Quarter-wave magnitude at i * (pi/2) / 16, i = 0..16
  function automatic logic [MAG_W-1:0] qwave(input logic [LUT_AW:0] i);
    logic [MAG_W-1:0] v;
    case (i)
      5'd0:    v = 12'd0;
      5'd1:    v = 12'd401;
      5'd2:    v = 12'd799;
      5'd3:    v = 12'd1189;
      5'd4:    v = 12'd1567;
      5'd5:    v = 12'd1930;
      5'd6:    v = 12'd2275;
      5'd7:    v = 12'd2598;
      5'd8:    v = 12'd2896;
      5'd9:    v = 12'd3165;
      5'd10:   v = 12'd3405;
      5'd11:   v = 12'd3611;
      5'd12:   v = 12'd3783;
      5'd13:   v = 12'd3919;
      5'd14:   v = 12'd4016;
      5'd15:   v = 12'd4075;
      default: v = 12'd4095;
    endcase
    return v;
  endfunction

  // Level-stage switches S6..S1 for each output level
  function automatic logic [5:0] level_pattern(input level_t l);
    logic [5:0] p;
    case (l)
      2'd0:    p = 6'b101010;
      2'd1:    p = 6'b011010;
      2'd2:    p = 6'b000110;
      default: p = 6'b000001;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ml7_ref_gen.sv
module ml7_ref_gen
  import ml7_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] ftw_i,
  input  logic [AMP_W-1:0]   amp_i,
  output logic [MAG_W-1:0]   mag_o,
  output logic               neg_o,
  output logic               vld_o
);

  localparam int QW     = PHASE_W - 2;
  localparam int FRAC_W = QW - LUT_AW;
  localparam int IW     = MAG_W + FRAC_W;
  localparam int SW     = MAG_W + AMP_W;

  logic [PHASE_W-1:0] phase_q, phase_d;
  logic [MAG_W-1:0]   mag_q, mag_d;
  logic               neg_q, neg_d;
  logic               vld_q, vld_d;
  logic               samp_en;

  logic [QW-1:0]      q_raw, q_mir;
  logic [LUT_AW-1:0]  idx;
  logic [LUT_AW:0]    idx_lo, idx_hi;
  logic [FRAC_W-1:0]  frac;
  logic [MAG_W-1:0]   base, apex, rise, interp;
  logic [IW-1:0]      ramp;
  logic [SW-1:0]      scaled;

  assign samp_en = 1'b1;

  always_comb begin
    q_raw  = phase_q[QW-1:0];
    q_mir  = phase_q[QW] ? ~q_raw : q_raw;
    idx    = q_mir[QW-1 -: LUT_AW];
    frac   = q_mir[FRAC_W-1:0];
    idx_lo = {1'b0, idx};
    idx_hi = idx_lo + 1'b1;
    base   = qwave(idx_lo);
    apex   = qwave(idx_hi);
    rise   = apex - base;
    ramp   = IW'(rise) * IW'(frac);
    interp = base + ramp[IW-1:FRAC_W];
    scaled = SW'(interp) * SW'(amp_i);
    mag_d  = scaled[SW-1:AMP_W];
    neg_d  = phase_q[PHASE_W-1];
    phase_d = phase_q + ftw_i;
    vld_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      mag_q   <= '0;
      neg_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else if (samp_en) begin
      phase_q <= phase_d;
      mag_q   <= mag_d;
      neg_q   <= neg_d;
      vld_q   <= vld_d;
    end
  end

  assign mag_o = mag_q;
  assign neg_o = neg_q;
  assign vld_o = vld_q;

endmodule

// File: rtl/ml7_carrier.sv
module ml7_carrier
  import ml7_pkg::*;
#(
  parameter int STEP = 65
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [MAG_W-1:0] car_o
);

  localparam logic [MAG_W-1:0] PEAK_V = MAG_W'(CAR_PEAK);
  localparam logic [MAG_W-1:0] STEP_V = MAG_W'(STEP);

  logic [MAG_W-1:0] car_q, car_d, out_q;
  logic             up_q, up_d;
  logic             samp_en;

  assign samp_en = 1'b1;

  always_comb begin
    car_d = car_q;
    up_d  = up_q;
    if (up_q) begin
      if (car_q >= PEAK_V - STEP_V) begin
        car_d = PEAK_V;
        up_d  = 1'b0;
      end else begin
        car_d = car_q + STEP_V;
      end
    end else begin
      if (car_q <= STEP_V) begin
        car_d = '0;
        up_d  = 1'b1;
      end else begin
        car_d = car_q - STEP_V;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_q <= '0;
      up_q  <= 1'b1;
      out_q <= '0;
    end else if (samp_en) begin
      car_q <= car_d;
      up_q  <= up_d;
      out_q <= car_q;
    end
  end

  assign car_o = out_q;

endmodule

// File: rtl/ml7_level_cmp.sv
module ml7_level_cmp
  import ml7_pkg::*;
(
  input  logic [MAG_W-1:0] mag_i,
  input  logic [MAG_W-1:0] car_i,
  output level_t           level_o
);

  localparam int TW = MAG_W + 1;

  logic [N_CMP-1:0] hit;

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    logic [TW-1:0] thr;
    always_comb begin
      thr    = TW'(k * CAR_PEAK) + {1'b0, car_i};
      hit[k] = {1'b0, mag_i} > thr;
    end
  end

  always_comb begin
    level_o = '0;
    for (int i = 0; i < N_CMP; i++) begin
      level_o = level_o + level_t'(hit[i]);
    end
  end

endmodule

// File: rtl/ml7_gate_map.sv
module ml7_gate_map
  import ml7_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld_i,
  input  logic            neg_i,
  input  level_t          level_i,
  output logic [N_SW-1:0] gate_o
);

  logic [N_SW-1:0] gate_q, gate_d;
  logic [5:0]      pat;
  logic [3:0]      pol;
  logic            load_en;

  assign load_en = 1'b1;

  always_comb begin
    pat    = level_pattern(level_i);
    pol    = neg_i ? 4'b1100 : 4'b0011;
    gate_d = vld_i ? {pol, pat} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
    end else if (load_en) begin
      gate_q <= gate_d;
    end
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/ml7_gate_gen.sv
module ml7_gate_gen
  import ml7_pkg::*;
#(
  parameter int PHASE_W  = 16,
  parameter int AMP_W    = 8,
  parameter int CAR_STEP = 65
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] ftw_i,
  input  logic [AMP_W-1:0]   amp_i,
  output logic [N_SW-1:0]    gate_o
);

  logic [MAG_W-1:0] mag;
  logic [MAG_W-1:0] car;
  logic             neg;
  logic             vld;
  level_t           level;

  ml7_ref_gen #(
    .PHASE_W (PHASE_W),
    .AMP_W   (AMP_W)
  ) u_ref (
    .clk   (clk),
    .rst_n (rst_n),
    .ftw_i (ftw_i),
    .amp_i (amp_i),
    .mag_o (mag),
    .neg_o (neg),
    .vld_o (vld)
  );

  ml7_carrier #(
    .STEP (CAR_STEP)
  ) u_car (
    .clk   (clk),
    .rst_n (rst_n),
    .car_o (car)
  );

  ml7_level_cmp u_cmp (
    .mag_i   (mag),
    .car_i   (car),
    .level_o (level)
  );

  ml7_gate_map u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_i   (vld),
    .neg_i   (neg),
    .level_i (level),
    .gate_o  (gate_o)
  );

endmodule

// File: rtl/ml7_gate_gen_chk.sv
module ml7_gate_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [9:0] gate
);

  // R1: outputs forced low while reset is held
  a_r1_reset_low: assert property (@(posedge clk) !rst_n |-> gate == 10'd0);

  // R1: once a vector is driven it never drops back to all-off
  a_r1_stays_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (|gate) |=> (|gate));

  // R5: only the four legal level-stage patterns appear
  a_r5_legal_level: assert property (@(posedge clk) disable iff (!rst_n)
    (|gate) |-> (gate[5:0] inside {6'b101010, 6'b011010, 6'b000110, 6'b000001}));

  // R6: S2 complements S1
  a_r6_s2_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (|gate) |-> (gate[1] != gate[0]));

  // R7: exactly one polarity pair conducts, both switches of it together
  a_r7_one_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (|gate) |-> ($countones(gate[9:6]) == 2 && gate[6] == gate[7] && gate[8] == gate[9]));

endmodule

bind ml7_gate_gen ml7_gate_gen_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .gate  (gate_o)
);

// File: tb/ml7_gate_gen_bench.sv
module ml7_gate_gen_bench;

  localparam int PEAK = 1365;
  localparam int STEP = 65;
  localparam int TOL  = 10;

  logic        clk;
  logic        rst_n;
  logic [15:0] ftw_i;
  logic [7:0]  amp_i;
  logic [9:0]  gate_o;

  typedef struct {
    bit neg;
    int lo;
    int hi;
    bit amp0;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  int   cnt     = 0;
  int   lvl3_pos = 0;
  int   lvl3_neg = 0;

  ml7_gate_gen u_ml7_gate_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .ftw_i  (ftw_i),
    .amp_i  (amp_i),
    .gate_o (gate_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int level_of(input real x, input int c);
    int n = 0;
    for (int k = 1; k <= 3; k++) if (x > real'((k - 1) * PEAK + c)) n++;
    return n;
  endfunction

  function automatic int decode(input logic [5:0] p);
    case (p)
      6'b101010: return 0;
      6'b011010: return 1;
      6'b000110: return 2;
      6'b000001: return 3;
      default:   return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) cnt <= 0;
    else        cnt <= cnt + 1;
  end

  // Monitor: compares each produced vector with the next expected item
  always @(negedge clk) begin
    if (rst_n && cnt == 1) begin
      check(gate_o == 10'd0, "R1 first edge idle", int'(gate_o), 0);
    end else if (rst_n && cnt >= 2 && q.size() > 0) begin
      exp_t e;
      int   lvl;
      e   = q.pop_front();
      lvl = decode(gate_o[5:0]);
      check(lvl >= 0, "R5 level pattern", int'(gate_o[5:0]), 0);
      check(gate_o[1] == ~gate_o[0], "R6 S2 inverse of S1", int'(gate_o[1:0]), 1);
      check(gate_o[9:6] == (e.neg ? 4'b1100 : 4'b0011), "R7 polarity pair",
            int'(gate_o[9:6]), e.neg ? 12 : 3);
      if (e.amp0)
        check(lvl == 0, "R8 zero amplitude level", lvl, 0);
      else
        check(lvl >= e.lo && lvl <= e.hi, "R4 level R2 R3 reference carrier", lvl, e.lo);
      if (lvl == 3) begin
        if (e.neg) lvl3_neg++;
        else       lvl3_pos++;
      end
    end
  end

  // Driver: reset, push expected items, release, wait for drain
  task automatic run(input int ftw, input int amp, input int n);
    int  ph = 0;
    int  c  = 0;
    bit  up = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    ftw_i = 16'(ftw);
    amp_i = 8'(amp);
    @(negedge clk);
    check(gate_o == 10'd0, "R1 reset state", int'(gate_o), 0);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      int   qv;
      real  ideal;
      real  tol;
      qv = ph & 16'h3FFF;
      if (((ph >> 14) & 1) == 1) qv = 16383 - qv;
      ideal  = (real'(amp) / 256.0) * 4095.0 * $sin(3.14159265358979 * real'(qv) / 32768.0);
      tol    = (amp == 0) ? 0.0 : real'(TOL);
      e.neg  = ((ph >> 15) & 1) == 1;
      e.lo   = level_of(ideal - tol, c);
      e.hi   = level_of(ideal + tol, c);
      e.amp0 = (amp == 0);
      q.push_back(e);
      ph = (ph + ftw) & 16'hFFFF;
      if (up) begin
        if (c + STEP >= PEAK) begin c = PEAK; up = 1'b0; end
        else c = c + STEP;
      end else begin
        if (c <= STEP) begin c = 0; up = 1'b1; end
        else c = c - STEP;
      end
    end
    lvl3_pos = 0;
    lvl3_neg = 0;
    @(negedge clk);
    rst_n = 1'b1;
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    ftw_i = '0;
    amp_i = '0;
    repeat (3) @(negedge clk);
    check(gate_o == 10'd0, "R1 power-up reset", int'(gate_o), 0);

    run(64, 230, 1100);
    check(lvl3_pos > 0, "R9 level 3 positive half", lvl3_pos, 1);
    check(lvl3_neg > 0, "R9 level 3 negative half", lvl3_neg, 1);

    run(64, 0, 600);
    check(lvl3_pos + lvl3_neg == 0, "R8 no level 3 at zero amplitude", lvl3_pos + lvl3_neg, 0);

    run(300, 255, 400);
    run(0, 200, 80);
    run(16'h8000, 255, 80);
    run(16'h4000, 255, 200);
    check(lvl3_neg > 0, "R7 level 3 in negative half at crest", lvl3_neg, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule